// File: doc/BRIEF.md
# Owner-Routed Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses raised by the resources of an audio data-movement subsystem and turns them into interrupts. The resources are DMA channels, serial audio interfaces, interface groups and rate detectors. Each pulse lands in a sticky status bit. The bit sits in the status register of its event class, and its position is the index of the resource that raised the pulse. Software clears status bits by writing ones.

A second level summarises these bits for each execution engine. Ownership maps assign every resource to one engine. An engine's summary register has one bit per event class. That bit is set while any enabled status bit of a resource the engine owns is pending in that class. Each engine has its own summary enable mask, its own class-wide clear register and its own level interrupt line. An engine therefore never sees events from resources it does not own.

The event classes, by bit index, are:

| Bit | Event class | Indexed by |
|-----|-------------|------------|
| 0 | DMA period | DMA channel |
| 1 | DMA under/overflow | DMA channel |
| 2 | bus error response | DMA channel |
| 3 | interface under/overflow | interface |
| 4 | group done | group |
| 5 | rate detector | rate detector |
| 6 | variable frame rate | interface |

Top module: `irq_route_agg`

## Requirements
- R1: After reset, the following are all zero: every status, resource-enable, ownership, summary and summary-enable register. Every `irq` bit is low.
- R2: An event pulse in a cycle sets status bit i of class c after the next clock edge. Status of class c is read at address 0x00+c, and bit i is resource i. The bit stays set until it is cleared.
- R3: Writing address 0x00+c clears exactly the status bits of class c whose write-data bit is one. Zero bits in the write data leave their status bits unchanged.
- R4: An event that arrives in the same cycle as a clear of its bit wins, so the bit stays set.
- R5: Ownership registers sit at 0x10 (DMA, used by classes 0, 1 and 2), 0x11 (interfaces, used by classes 3 and 6), 0x12 (groups, used by class 4) and 0x13 (rate detectors, used by class 5). Resource i uses bits [3i+2:3i]. Bit c of engine e's summary counts only resources whose field equals e.
- R6: The resource-enable register at 0x08+c masks the status of class c out of every summary. The status bits themselves still record events.
- R7: The summary of engine e is read at 0x18+e. It is read-only, and writes to it have no effect.
- R8: `irq[e]` is high exactly while the summary of engine e ANDed with its summary-enable register at 0x20+e (bit c is class c) is non-zero.
- R9: Writing a class mask to 0x28+e clears the status bits of those classes for resources owned by engine e only. The address reads back as zero.
- R10: An ownership field of value N_ENG or above routes its resource to no engine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_dma_period | input | N_DMA | DMA period event pulses |
| ev_dma_xrun | input | N_DMA | DMA under/overflow pulses |
| ev_bus_err | input | N_DMA | DMA bus error pulses |
| ev_if_xrun | input | N_IF | Interface under/overflow pulses |
| ev_grp_done | input | N_GRP | Group done pulses |
| ev_rate | input | N_RD | Rate detector pulses |
| ev_vfr | input | N_IF | Variable frame rate pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Read data, combinational from rd_addr |
| irq | output | N_ENG | Level interrupt, one per engine |

## Verification
Two things can collide in one cycle on the same status bit: a new event pulse and a software clear. The clear can come through a write-one to the status register or through an engine's class clear. The bench provokes this directly for both clear paths. Long random runs then keep producing the same coincidence by chance, at the same time as ownership changes. A behavioural model applies the rule that the event wins. It compares the read port and every interrupt line each cycle, so a lost event shows up as a status or interrupt mismatch.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NCLS = 7;
  localparam int NDOM = 4;

  typedef enum logic [2:0] {
    CLS_DMA_PER  = 3'd0,
    CLS_DMA_XRUN = 3'd1,
    CLS_BUS_ERR  = 3'd2,
    CLS_IF_XRUN  = 3'd3,
    CLS_GRP_DONE = 3'd4,
    CLS_RATE     = 3'd5,
    CLS_VFR      = 3'd6
  } ev_class_e;

  localparam int DOM_DMA  = 0;
  localparam int DOM_IF   = 1;
  localparam int DOM_GRP  = 2;
  localparam int DOM_RATE = 3;

  localparam int STAT_BASE = 'h00;
  localparam int REN_BASE  = 'h08;
  localparam int OWN_BASE  = 'h10;
  localparam int SUM_BASE  = 'h18;
  localparam int SEN_BASE  = 'h20;
  localparam int ECLR_BASE = 'h28;

  // resource domain that indexes the bits of an event class
  function automatic int class_domain(input int cls);
    case (cls)
      int'(CLS_DMA_PER), int'(CLS_DMA_XRUN), int'(CLS_BUS_ERR): return DOM_DMA;
      int'(CLS_IF_XRUN), int'(CLS_VFR):                         return DOM_IF;
      int'(CLS_GRP_DONE):                                       return DOM_GRP;
      default:                                                  return DOM_RATE;
    endcase
  endfunction
endpackage

// File: rtl/irq_owner_map.sv
module irq_owner_map
  import irq_agg_pkg::*;
#(
  parameter int N_DMA = 8,
  parameter int N_IF  = 4,
  parameter int N_GRP = 2,
  parameter int N_RD  = 2,
  parameter int MAXR  = 8,
  parameter int OW    = 3,
  parameter int AW    = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [AW-1:0]                       wr_addr,
  input  logic [OW*MAXR-1:0]                  wr_fields,
  output logic [NDOM-1:0][MAXR-1:0][OW-1:0]   own_q,
  output logic [NDOM-1:0][OW*MAXR-1:0]        map_view
);
  localparam int DOM_CNT [NDOM] = '{N_DMA, N_IF, N_GRP, N_RD};

  logic [NDOM-1:0]                      map_hit;
  logic [NDOM-1:0][MAXR-1:0][OW-1:0]    own_d;
  logic                                 map_upd;

  genvar d, i;
  generate
    for (d = 0; d < NDOM; d++) begin : g_dom
      assign map_hit[d] = wr_en && (wr_addr == AW'(OWN_BASE + d));
      for (i = 0; i < MAXR; i++) begin : g_res
        if (i < DOM_CNT[d]) begin : g_live
          assign own_d[d][i] = map_hit[d] ? wr_fields[OW*i +: OW] : own_q[d][i];
        end else begin : g_pad
          assign own_d[d][i] = '0;
        end
        assign map_view[d][OW*i +: OW] = own_q[d][i];
      end
    end
  endgenerate

  assign map_upd = |map_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
    end else if (map_upd) begin
      own_q <= own_d;
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter int MAXR = 8,
  parameter int AW   = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  wr_addr,
  input  logic [MAXR-1:0]                wr_bits,
  input  logic [NCLS-1:0][MAXR-1:0]      ev_vec,
  input  logic [NCLS-1:0][MAXR-1:0]      eng_clr,
  input  logic [NCLS-1:0][MAXR-1:0]      cls_valid,
  output logic [NCLS-1:0][MAXR-1:0]      stat_q,
  output logic [NCLS-1:0][MAXR-1:0]      ren_q
);
  logic [NCLS-1:0][MAXR-1:0] stat_d, ren_d, w1c, clr_all;
  logic [NCLS-1:0]           stat_upd, ren_hit;

  genvar c;
  generate
    for (c = 0; c < NCLS; c++) begin : g_cls
      assign w1c[c]     = (wr_en && (wr_addr == AW'(STAT_BASE + c))) ? wr_bits : '0;
      assign clr_all[c] = w1c[c] | eng_clr[c];
      // a pulse in the clearing cycle is ORed in after the clear, so it wins
      assign stat_d[c]   = ((stat_q[c] & ~clr_all[c]) | ev_vec[c]) & cls_valid[c];
      assign stat_upd[c] = |(clr_all[c] | ev_vec[c]);

      assign ren_hit[c] = wr_en && (wr_addr == AW'(REN_BASE + c));
      assign ren_d[c]   = ren_hit[c] ? (wr_bits & cls_valid[c]) : ren_q[c];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q[c] <= '0;
        end else if (stat_upd[c]) begin
          stat_q[c] <= stat_d[c];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ren_q[c] <= '0;
        end else if (ren_hit[c]) begin
          ren_q[c] <= ren_d[c];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/irq_engine_view.sv
module irq_engine_view
  import irq_agg_pkg::*;
#(
  parameter int ENG_IDX = 0,
  parameter int MAXR    = 8,
  parameter int OW      = 3,
  parameter int AW      = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [NCLS-1:0]                   wr_mask,
  input  logic [NCLS-1:0][MAXR-1:0]         stat_q,
  input  logic [NCLS-1:0][MAXR-1:0]         ren_q,
  input  logic [NCLS-1:0][MAXR-1:0]         cls_valid,
  input  logic [NDOM-1:0][MAXR-1:0][OW-1:0] own_q,
  output logic [NCLS-1:0]                   sum,
  output logic [NCLS-1:0]                   sen_q,
  output logic [NCLS-1:0][MAXR-1:0]         clr_req,
  output logic                              irq
);
  logic [NCLS-1:0][MAXR-1:0] owned;
  logic [NCLS-1:0]           sen_d;
  logic                      sen_hit, eclr_hit;

  assign sen_hit  = wr_en && (wr_addr == AW'(SEN_BASE + ENG_IDX));
  assign eclr_hit = wr_en && (wr_addr == AW'(ECLR_BASE + ENG_IDX));

  genvar c, i;
  generate
    for (c = 0; c < NCLS; c++) begin : g_cls
      for (i = 0; i < MAXR; i++) begin : g_res
        assign owned[c][i] = cls_valid[c][i] &&
                             (own_q[class_domain(c)][i] == OW'(ENG_IDX));
      end
      assign sum[c]     = |(stat_q[c] & ren_q[c] & owned[c]);
      assign clr_req[c] = (eclr_hit && wr_mask[c]) ? owned[c] : '0;
    end
  endgenerate

  always_comb begin
    sen_d = sen_q;
    if (sen_hit) sen_d = wr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_q <= '0;
    end else if (sen_hit) begin
      sen_q <= sen_d;
    end
  end

  assign irq = |(sum & sen_q);
endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
  import irq_agg_pkg::*;
#(
  parameter int N_DMA = 8,
  parameter int N_IF  = 4,
  parameter int N_GRP = 2,
  parameter int N_RD  = 2,
  parameter int N_ENG = 5,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DMA-1:0] ev_dma_period,
  input  logic [N_DMA-1:0] ev_dma_xrun,
  input  logic [N_DMA-1:0] ev_bus_err,
  input  logic [N_IF-1:0]  ev_if_xrun,
  input  logic [N_GRP-1:0] ev_grp_done,
  input  logic [N_RD-1:0]  ev_rate,
  input  logic [N_IF-1:0]  ev_vfr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [N_ENG-1:0] irq
);
  localparam int MAXA = (N_DMA > N_IF) ? N_DMA : N_IF;
  localparam int MAXB = (N_GRP > N_RD) ? N_GRP : N_RD;
  localparam int MAXR = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int OW   = (N_ENG > 1) ? $clog2(N_ENG + 1) : 1;
  localparam int DOM_CNT [NDOM] = '{N_DMA, N_IF, N_GRP, N_RD};

  logic [NCLS-1:0][MAXR-1:0]             ev_vec, stat_q, ren_q, cls_valid, eng_clr;
  logic [NDOM-1:0][MAXR-1:0][OW-1:0]     own_q;
  logic [NDOM-1:0][OW*MAXR-1:0]          map_view;
  logic [N_ENG-1:0][NCLS-1:0]            eng_sum, eng_sen;
  logic [N_ENG-1:0][NCLS-1:0][MAXR-1:0]  eng_clr_req;
  logic                                  unused_wd;

  assign unused_wd = ^wr_data;

  assign ev_vec[CLS_DMA_PER]  = MAXR'(ev_dma_period);
  assign ev_vec[CLS_DMA_XRUN] = MAXR'(ev_dma_xrun);
  assign ev_vec[CLS_BUS_ERR]  = MAXR'(ev_bus_err);
  assign ev_vec[CLS_IF_XRUN]  = MAXR'(ev_if_xrun);
  assign ev_vec[CLS_GRP_DONE] = MAXR'(ev_grp_done);
  assign ev_vec[CLS_RATE]     = MAXR'(ev_rate);
  assign ev_vec[CLS_VFR]      = MAXR'(ev_vfr);

  genvar c, i, e;
  generate
    for (c = 0; c < NCLS; c++) begin : g_valid
      for (i = 0; i < MAXR; i++) begin : g_bit
        assign cls_valid[c][i] = (i < DOM_CNT[class_domain(c)]);
      end
    end
  endgenerate

  irq_owner_map #(
    .N_DMA(N_DMA), .N_IF(N_IF), .N_GRP(N_GRP), .N_RD(N_RD),
    .MAXR(MAXR), .OW(OW), .AW(AW)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_fields(wr_data[OW*MAXR-1:0]), .own_q(own_q), .map_view(map_view)
  );

  irq_status_bank #(.MAXR(MAXR), .AW(AW)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[MAXR-1:0]), .ev_vec(ev_vec), .eng_clr(eng_clr),
    .cls_valid(cls_valid), .stat_q(stat_q), .ren_q(ren_q)
  );

  generate
    for (e = 0; e < N_ENG; e++) begin : g_eng
      irq_engine_view #(.ENG_IDX(e), .MAXR(MAXR), .OW(OW), .AW(AW)) u_view (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mask(wr_data[NCLS-1:0]), .stat_q(stat_q), .ren_q(ren_q),
        .cls_valid(cls_valid), .own_q(own_q), .sum(eng_sum[e]),
        .sen_q(eng_sen[e]), .clr_req(eng_clr_req[e]), .irq(irq[e])
      );
    end
  endgenerate

  always_comb begin
    eng_clr = '0;
    for (int k = 0; k < N_ENG; k++) eng_clr = eng_clr | eng_clr_req[k];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (rd_addr == AW'(STAT_BASE + k)) rd_data = DW'(stat_q[k]);
      if (rd_addr == AW'(REN_BASE + k))  rd_data = DW'(ren_q[k]);
    end
    for (int k = 0; k < NDOM; k++) begin
      if (rd_addr == AW'(OWN_BASE + k)) rd_data = DW'(map_view[k]);
    end
    for (int k = 0; k < N_ENG; k++) begin
      if (rd_addr == AW'(SUM_BASE + k)) rd_data = DW'(eng_sum[k]);
      if (rd_addr == AW'(SEN_BASE + k)) rd_data = DW'(eng_sen[k]);
    end
  end
endmodule

// File: rtl/irq_route_agg_chk.sv
module irq_route_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int MAXR  = 8,
  parameter int N_ENG = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [NCLS-1:0][MAXR-1:0] ev_vec,
  input logic [NCLS-1:0][MAXR-1:0] stat_q,
  input logic [NCLS-1:0][MAXR-1:0] cls_valid,
  input logic [N_ENG-1:0]          irq
);
  genvar c, i;
  generate
    for (c = 0; c < NCLS; c++) begin : g_c
      for (i = 0; i < MAXR; i++) begin : g_i
        if (i < MAXR) begin : g_on
          // R2 R4
          ev_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_vec[c][i] && cls_valid[c][i]) |=> stat_q[c][i]);
        end
      end
    end
  endgenerate

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> (stat_q != '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0 && stat_q == '0));

  // R2
  status_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~cls_valid) == '0);
endmodule

bind irq_route_agg irq_route_agg_chk #(.MAXR(MAXR), .N_ENG(N_ENG)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ev_vec(ev_vec),
  .stat_q(stat_q), .cls_valid(cls_valid), .irq(irq)
);

// File: tb/irq_route_agg_tb_top.sv
module irq_route_agg_tb_top;
  localparam int ND = 8, NI = 4, NG = 2, NR = 2, NE = 5;

  logic clk, rst_n;
  logic [ND-1:0] ev_dma_period, ev_dma_xrun, ev_bus_err;
  logic [NI-1:0] ev_if_xrun, ev_vfr;
  logic [NG-1:0] ev_grp_done;
  logic [NR-1:0] ev_rate;
  logic          wr_en;
  logic [5:0]    wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic [NE-1:0] irq;

  irq_route_agg dut_i (
    .clk(clk), .rst_n(rst_n), .ev_dma_period(ev_dma_period), .ev_dma_xrun(ev_dma_xrun),
    .ev_bus_err(ev_bus_err), .ev_if_xrun(ev_if_xrun), .ev_grp_done(ev_grp_done),
    .ev_rate(ev_rate), .ev_vfr(ev_vfr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model
  logic [31:0] m_stat [7];
  logic [31:0] m_en   [7];
  logic [31:0] m_own  [4];
  logic [31:0] m_sen  [NE];
  logic [31:0] nx_ev  [7];
  logic [5:0]  cur_ra;
  string       cur_tag;

  function automatic int dom_of(int c);
    if (c <= 2) return 0;
    if (c == 3 || c == 6) return 1;
    if (c == 4) return 2;
    return 3;
  endfunction
  function automatic int cnt_of(int d);
    int t [4] = '{ND, NI, NG, NR};
    return t[d];
  endfunction
  function automatic logic [31:0] vmask(int c);
    return (32'd1 << cnt_of(dom_of(c))) - 1;
  endfunction
  function automatic int owner(int c, int i);
    return int'((m_own[dom_of(c)] >> (3*i)) & 32'd7);
  endfunction
  function automatic logic [31:0] exp_sum(int e);
    logic [31:0] s = 0;
    for (int c = 0; c < 7; c++)
      for (int i = 0; i < cnt_of(dom_of(c)); i++)
        if (m_stat[c][i] && m_en[c][i] && owner(c, i) == e) s[c] = 1'b1;
    return s;
  endfunction
  function automatic logic [31:0] exp_rd(logic [5:0] a);
    int x = int'(a);
    if (x < 7) return m_stat[x];
    if (x >= 8 && x < 15) return m_en[x-8];
    if (x >= 16 && x < 20) return m_own[x-16];
    if (x >= 24 && x < 24+NE) return exp_sum(x-24);
    if (x >= 32 && x < 32+NE) return m_sen[x-32];
    return 32'd0;
  endfunction
  function automatic string tag_of(logic [5:0] a);
    int x = int'(a);
    if (x < 8) return "R2";
    if (x < 16) return "R6";
    if (x < 24) return "R5";
    if (x < 32) return "R7";
    if (x < 40) return "R8";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [5:0] wa, logic [31:0] wd, logic [5:0] ra, string tag);
    logic [31:0] clr [7];
    logic [NE-1:0] ei;
    @(negedge clk);
    chk(cur_tag, rd_data, exp_rd(cur_ra));
    ei = '0;
    for (int e = 0; e < NE; e++) ei[e] = |(exp_sum(e) & m_sen[e]);
    chk("R8", {27'd0, irq}, {27'd0, ei});
    // drive
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    ev_dma_period = nx_ev[0][ND-1:0]; ev_dma_xrun = nx_ev[1][ND-1:0];
    ev_bus_err = nx_ev[2][ND-1:0];    ev_if_xrun = nx_ev[3][NI-1:0];
    ev_grp_done = nx_ev[4][NG-1:0];   ev_rate = nx_ev[5][NR-1:0];
    ev_vfr = nx_ev[6][NI-1:0];
    // model next state
    for (int c = 0; c < 7; c++) begin
      clr[c] = 0;
      if (we && int'(wa) == c) clr[c] = wd;
      for (int e = 0; e < NE; e++)
        if (we && int'(wa) == 40+e && wd[c])
          for (int i = 0; i < cnt_of(dom_of(c)); i++)
            if (owner(c, i) == e) clr[c][i] = 1'b1;
    end
    for (int c = 0; c < 7; c++)
      m_stat[c] = ((m_stat[c] & ~clr[c]) | nx_ev[c]) & vmask(c);
    if (we) begin
      int x = int'(wa);
      if (x >= 8 && x < 15) m_en[x-8] = wd & vmask(x-8);
      if (x >= 16 && x < 20) m_own[x-16] = wd & ((32'd1 << (3*cnt_of(x-16))) - 1);
      if (x >= 32 && x < 32+NE) m_sen[x-32] = wd & 32'h7F;
    end
    for (int c = 0; c < 7; c++) nx_ev[c] = 0;
    cur_ra = ra;
    cur_tag = (tag == "") ? tag_of(ra) : tag;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    ev_dma_period = 0; ev_dma_xrun = 0; ev_bus_err = 0; ev_if_xrun = 0;
    ev_grp_done = 0; ev_rate = 0; ev_vfr = 0;
    for (int c = 0; c < 7; c++) begin m_stat[c] = 0; m_en[c] = 0; nx_ev[c] = 0; end
    for (int k = 0; k < 4; k++) m_own[k] = 0;
    for (int e = 0; e < NE; e++) m_sen[e] = 0;
    cur_ra = 0; cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every register reads zero after reset
    for (int a = 0; a < 48; a++) cyc(0, 0, 0, 6'(a), "R1");
    // ownership setup (R5)
    d = 0; for (int i = 0; i < ND; i++) d[3*i +: 3] = 3'(i % NE);
    cyc(1, 6'h10, d, 6'h10, "R5");
    d = 0; for (int i = 0; i < NI; i++) d[3*i +: 3] = 3'((i + 1) % NE);
    cyc(1, 6'h11, d, 6'h11, "R5");
    cyc(1, 6'h12, 32'h1A, 6'h12, "R5");
    cyc(1, 6'h13, 32'h04, 6'h13, "R5");
    for (int c = 0; c < 7; c++) cyc(1, 6'(8 + c), 32'hFF, 6'(8 + c), "R6");
    for (int e = 0; e < NE; e++) cyc(1, 6'(32 + e), 32'h7F, 6'(32 + e), "R8");
    // R2: DMA channel 3 period event reaches engine 3
    nx_ev[0] = 32'h08;
    cyc(0, 0, 0, 6'h00, "R2");
    cyc(0, 0, 0, 6'h1B, "R5");
    // R3: zero write leaves status, one clears it
    cyc(1, 6'h00, 32'h0, 6'h00, "R3");
    cyc(1, 6'h00, 32'h08, 6'h00, "R3");
    // R4: event and write-one-clear in the same cycle
    nx_ev[3] = 32'h2;
    cyc(0, 0, 0, 6'h03, "R2");
    nx_ev[3] = 32'h2;
    cyc(1, 6'h03, 32'h2, 6'h03, "R4");
    // R6: resource enable masks summary only
    cyc(1, 6'h0B, 32'h0, 6'h1A, "R6");
    cyc(0, 0, 0, 6'h03, "R6");
    cyc(1, 6'h0B, 32'hFF, 6'h1A, "R6");
    // R7: summary write is ignored
    cyc(1, 6'h1A, 32'h0, 6'h1A, "R7");
    // R4 through engine clear, then R9 clear
    nx_ev[3] = 32'h2;
    cyc(1, 6'h2A, 32'h08, 6'h03, "R4");
    cyc(1, 6'h2A, 32'h08, 6'h03, "R9");
    cyc(0, 0, 0, 6'h2A, "R9");
    // R9: clear by a non-owning engine has no effect
    nx_ev[0] = 32'h01;
    cyc(0, 0, 0, 6'h00, "R2");
    cyc(1, 6'h2B, 32'h01, 6'h00, "R9");
    // R10: owner field 7 routes nowhere
    cyc(1, 6'h10, 32'h00FA_C887, 6'h18, "R10");
    cyc(0, 0, 0, 6'h18, "R10");
    // R8: summary enable off drops the line
    cyc(1, 6'h10, 32'h0, 6'h18, "R8");
    cyc(1, 6'h20, 32'h0, 6'h20, "R8");
    cyc(1, 6'h20, 32'h7F, 6'h18, "R8");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic we; logic [5:0] wa; logic [31:0] wd;
      for (int c = 0; c < 7; c++) begin
        d = $urandom;
        nx_ev[c] = ($urandom % 4 == 0) ? (d & ($urandom & $urandom)) : 32'd0;
      end
      we = ($urandom % 3 == 0);
      wa = 6'($urandom % 48);
      wd = $urandom;
      if (wa >= 6'h10 && wa < 6'h14 && ($urandom % 2 == 0)) wd = wd & 32'h0092_4924;
      cyc(we, wa, wd, 6'($urandom % 48), "");
    end
    cyc(0, 0, 0, 0, "");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule